// File: doc/BRIEF.md
# Johnson Decade Counter with One-Hot Decoder

This block counts through ten states and presents the count as ten one-hot decoded lines plus a carry. The count is kept in a five-bit twisted-ring (Johnson) register. Only one register bit changes per step, and each decoded line is the AND of two neighbouring register bits, so a decoded line never glitches through an intermediate code. The carry is high for the first half of the cycle (counts 0 to 4), which makes it a square wave at one tenth of the advance rate. It can drive the counting input of a further stage.

The counting clock and the inhibit input come from outside and are slow compared with the system clock. Each passes through a two-flop synchronizer, and the block detects edges on the synchronized copies. The count advances in two cases: on a rising counting clock while inhibit is low, or on a falling inhibit while the counting clock is high. A clear input forces count 0 at once, without waiting for a clock edge, and is released in step with the system clock. Feeding decoded line N back to the clear input gives a divide-by-N counter for N below ten. If the ring register ever holds a code outside the ten legal ones, the next advance loads count 0.

Top module: `johnson_decade_counter`

## Requirements
- R1: After `rst_n` is released, `dec_o` is 10'b0000000001 (count 0) and `carry_o` is 1.
- R2: At all times exactly one bit of `dec_o` is high, and bit k high means the count is k (bit 0 = count 0, bit 9 = count 9).
- R3: A rising edge of `cnt_clk_in` while `cnt_inh_in` is low advances the count by one. Count 9 advances to count 0.
- R4: A rising edge of `cnt_clk_in` while `cnt_inh_in` is high leaves the count unchanged.
- R5: A falling edge of `cnt_inh_in` while `cnt_clk_in` is high advances the count by one. A falling `cnt_inh_in` while `cnt_clk_in` is low does not, and a rising `cnt_inh_in` never does.
- R6: `carry_o` is 1 for counts 0 to 4 and 0 for counts 5 to 9, so it rises exactly when the count wraps from 9 to 0.
- R7: `clr_in` high forces count 0 on `dec_o` with no system clock edge needed, and holds it there while high. After release, counting resumes from 0. Feeding `dec_o` bit N back to `clr_in` limits the sequence to counts 0 to N-1.
- R8: A high level on `cnt_clk_in` that is already present when `rst_n` or `clr_in` is released is not taken as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all external inputs |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously |
| cnt_clk_in | input | 1 | Asynchronous counting clock |
| cnt_inh_in | input | 1 | Asynchronous count inhibit; its falling edge counts while `cnt_clk_in` is high |
| clr_in | input | 1 | Asynchronous active-high clear to count 0 |
| dec_o | output | 10 | One-hot decoded count |
| carry_o | output | 1 | High for counts 0 to 4 |

## Verification
The assertions check on every cycle that the decoded output is one-hot and that the carry agrees with it. They also check that each internal advance event rotates the one-hot output by one position, that without an event the output holds, that clear shows count 0, and that a rising carry lands on count 0. The bench's scenarios are needed to show which combinations of edges on the counting clock and the inhibit input actually produce an advance. They also show that a level present at reset or clear release is not counted, and that the divide-by-N feedback loop closes.

// File: rtl/jdc_pkg.sv
package jdc_pkg;
  // Number of flops in the twisted ring; the count length is twice this.
  localparam int unsigned DEF_RING_BITS   = 5;
  // Depth of the input synchronizers.
  localparam int unsigned DEF_SYNC_STAGES = 2;

  function automatic int unsigned ring_states(input int unsigned ring_bits);
    return 2 * ring_bits;
  endfunction
endpackage

// File: rtl/jdc_rst_sync.sv
module jdc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/jdc_edge_unit.sv
module jdc_edge_unit #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_clk_in,
  input  logic cnt_inh_in,
  output logic adv_o
);
  // Cycles after reset until the synchronizer and previous-value flops hold real input levels.
  localparam int unsigned ARM_CYC = SYNC_STAGES + 1;
  localparam int unsigned ARM_W   = $clog2(ARM_CYC + 1);

  logic [SYNC_STAGES-1:0] clk_sh_q, clk_sh_d;
  logic [SYNC_STAGES-1:0] inh_sh_q, inh_sh_d;
  logic                   clk_prev_q, clk_prev_d;
  logic                   inh_prev_q, inh_prev_d;
  logic [ARM_W-1:0]       arm_q, arm_d;
  logic                   armed;
  logic                   clk_lvl, inh_lvl;
  logic                   clk_rise, inh_fall;

  assign clk_lvl  = clk_sh_q[SYNC_STAGES-1];
  assign inh_lvl  = inh_sh_q[SYNC_STAGES-1];
  assign armed    = (arm_q == ARM_W'(ARM_CYC));
  assign clk_rise = clk_lvl & ~clk_prev_q;
  assign inh_fall = ~inh_lvl & inh_prev_q;

  always_comb begin
    clk_sh_d   = {clk_sh_q[SYNC_STAGES-2:0], cnt_clk_in};
    inh_sh_d   = {inh_sh_q[SYNC_STAGES-2:0], cnt_inh_in};
    clk_prev_d = clk_lvl;
    inh_prev_d = inh_lvl;
    arm_d      = armed ? arm_q : arm_q + ARM_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sh_q   <= '0;
      inh_sh_q   <= '0;
      clk_prev_q <= 1'b0;
      inh_prev_q <= 1'b0;
      arm_q      <= '0;
    end else begin
      clk_sh_q   <= clk_sh_d;
      inh_sh_q   <= inh_sh_d;
      clk_prev_q <= clk_prev_d;
      inh_prev_q <= inh_prev_d;
      arm_q      <= arm_d;
    end
  end

  // Advance: clock rises with inhibit low, or inhibit falls with clock high.
  assign adv_o = armed & ((clk_rise & ~inh_lvl) | (inh_fall & clk_lvl));
endmodule

// File: rtl/jdc_ring.sv
module jdc_ring #(
  parameter int unsigned RING_BITS = 5,
  localparam int unsigned NSTATES  = 2 * RING_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv_i,
  output logic [NSTATES-1:0] dec_o,
  output logic               carry_o
);
  logic [RING_BITS-1:0] ring_q, ring_d;
  logic [NSTATES-1:0]   dec;
  logic                 legal;

  // Each decoded line looks at one pair of neighbouring ring bits.
  for (genvar k = 0; k < NSTATES; k++) begin : g_dec
    if (k == 0) begin : g_zero
      assign dec[k] = ~ring_q[RING_BITS-1] & ~ring_q[0];
    end else if (k < RING_BITS) begin : g_fill
      assign dec[k] = ring_q[k-1] & ~ring_q[k];
    end else if (k == RING_BITS) begin : g_full
      assign dec[k] = ring_q[RING_BITS-1] & ring_q[0];
    end else begin : g_drain
      assign dec[k] = ~ring_q[k-RING_BITS-1] & ring_q[k-RING_BITS];
    end
  end

  // A legal ring code decodes to exactly one line; anything else reloads count 0.
  assign legal = $onehot(dec);

  always_comb begin
    ring_d = ring_q;
    if (adv_i) begin
      if (legal) ring_d = {ring_q[RING_BITS-2:0], ~ring_q[RING_BITS-1]};
      else       ring_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_q <= '0;
    else        ring_q <= ring_d;
  end

  assign dec_o   = dec;
  assign carry_o = ~ring_q[RING_BITS-1];
endmodule

// File: rtl/johnson_decade_counter.sv
module johnson_decade_counter
  import jdc_pkg::*;
#(
  parameter int unsigned RING_BITS   = DEF_RING_BITS,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  localparam int unsigned NSTATES    = ring_states(RING_BITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_clk_in,
  input  logic               cnt_inh_in,
  input  logic               clr_in,
  output logic [NSTATES-1:0] dec_o,
  output logic               carry_o
);
  logic sys_rst_n;
  logic clr_src_n;
  logic clr_rst_n;
  logic adv;

  assign clr_src_n = rst_n & ~clr_in;

  // The input path sees only the system reset, so a clear does not create false edges.
  jdc_rst_sync #(.STAGES(SYNC_STAGES)) u_sys_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (sys_rst_n)
  );

  jdc_rst_sync #(.STAGES(SYNC_STAGES)) u_clr_rst (
    .clk     (clk),
    .arst_n  (clr_src_n),
    .rst_n_o (clr_rst_n)
  );

  jdc_edge_unit #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst_n      (sys_rst_n),
    .cnt_clk_in (cnt_clk_in),
    .cnt_inh_in (cnt_inh_in),
    .adv_o      (adv)
  );

  jdc_ring #(.RING_BITS(RING_BITS)) u_ring (
    .clk     (clk),
    .rst_n   (clr_rst_n),
    .adv_i   (adv),
    .dec_o   (dec_o),
    .carry_o (carry_o)
  );
endmodule

// File: rtl/jdc_checker.sv
module jdc_checker #(
  parameter int unsigned RING_BITS = 5,
  localparam int unsigned NSTATES  = 2 * RING_BITS
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run_n,
  input logic               clr_in,
  input logic               adv,
  input logic [NSTATES-1:0] dec_o,
  input logic               carry_o
);
  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(dec_o));

  assert_carry_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o == (|dec_o[RING_BITS-1:0]));

  assert_step_rotate_R3: assert property (@(posedge clk) disable iff (!run_n)
    adv |=> dec_o == {$past(dec_o[NSTATES-2:0]), $past(dec_o[NSTATES-1])});

  assert_hold_no_event_R4: assert property (@(posedge clk) disable iff (!run_n)
    !adv |=> $stable(dec_o));

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_in |-> dec_o == NSTATES'(1));

  assert_carry_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carry_o) |-> dec_o[0]);
endmodule

bind johnson_decade_counter jdc_checker #(.RING_BITS(RING_BITS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run_n   (clr_rst_n),
  .clr_in  (clr_in),
  .adv     (adv),
  .dec_o   (dec_o),
  .carry_o (carry_o)
);

// File: tb/johnson_decade_counter_tb_top.sv
module johnson_decade_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, cnt_clk, cnt_inh, clr;
  logic [9:0] dec;
  logic       carry;

  int   n_chk = 0;
  int   n_bad = 0;
  int   cnt_m = 0;
  logic clk_m = 1'b0;
  logic inh_m = 1'b0;
  bit   done  = 1'b0;

  always #5 clk = ~clk;

  johnson_decade_counter dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_clk_in (cnt_clk),
    .cnt_inh_in (cnt_inh),
    .clr_in     (clr),
    .dec_o      (dec),
    .carry_o    (carry)
  );

  function automatic logic [9:0] exp_dec(input int c);
    return 10'(1) << c;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    chk(dec == exp_dec(cnt_m), {tag, " dec"}, 32'(dec), 32'(exp_dec(cnt_m)));
    chk(carry == (cnt_m < 5), {tag, " carry R6"}, 32'(carry), 32'(cnt_m < 5));
  endtask

  // Set both external inputs at a falling edge, predict, and let the sync pipeline settle.
  task automatic drive(input logic c, input logic i);
    bit adv;
    @(negedge clk);
    adv = (c && !clk_m && !i) || (!i && inh_m && c);
    cnt_clk = c;
    cnt_inh = i;
    clk_m   = c;
    inh_m   = i;
    if (adv) cnt_m = (cnt_m + 1) % 10;
    repeat (5) @(negedge clk);
  endtask

  task automatic clear_pulse();
    @(negedge clk);
    clr = 1'b1;
    #1;
    cnt_m = 0;
    chk(dec == 10'd1, "R7 async clear", 32'(dec), 32'd1);
    repeat (3) @(negedge clk);
    clr = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int max_seen;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cnt_clk = 1'b0; cnt_inh = 1'b0; clr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check_state("R1 reset");

    // R3: plain counting through the wrap.
    for (int k = 0; k < 12; k++) begin
      drive(1'b1, 1'b0);
      check_state("R3 rise");
      drive(1'b0, 1'b0);
      check_state("R2 fall no step");
    end

    // R4: rising clock with inhibit high.
    drive(1'b0, 1'b1);
    for (int k = 0; k < 3; k++) begin
      drive(1'b1, 1'b1);
      check_state("R4 inhibited rise");
      drive(1'b0, 1'b1);
    end

    // R5: inhibit edges.
    drive(1'b1, 1'b1);
    drive(1'b1, 1'b0);
    check_state("R5 inh fall clk high");
    drive(1'b1, 1'b1);
    check_state("R5 inh rise");
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b0);
    check_state("R5 inh fall clk low");

    // R7: clear holds count 0, counting resumes after release.
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    @(negedge clk);
    clr = 1'b1;
    #1;
    cnt_m = 0;
    chk(dec == 10'd1, "R7 async clear", 32'(dec), 32'd1);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); cnt_clk = 1'b1; repeat (4) @(negedge clk);
      @(negedge clk); cnt_clk = 1'b0; repeat (4) @(negedge clk);
      check_state("R7 held in clear");
    end
    clr = 1'b0;
    repeat (4) @(negedge clk);
    check_state("R7 release");
    drive(1'b1, 1'b0);
    check_state("R7 resume");
    drive(1'b0, 1'b0);

    // R7: divide-by-7 through feedback of decoded line 7.
    clear_pulse();
    max_seen = 0;
    for (int k = 0; k < 30; k++) begin
      drive(1'b1, 1'b0);
      drive(1'b0, 1'b0);
      if (dec[7]) clear_pulse();
      check_state("R7 divide-by-7");
      if (cnt_m > max_seen) max_seen = cnt_m;
    end
    chk(max_seen == 6, "R7 divide-by-7 range", 32'(max_seen), 32'd6);

    // R8: clock level high across reset release and across clear release.
    @(negedge clk);
    rst_n = 1'b0; cnt_clk = 1'b1; clk_m = 1'b1; cnt_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check_state("R8 high at reset release");
    clear_pulse();
    repeat (4) @(negedge clk);
    check_state("R8 high at clear release");
    drive(1'b0, 1'b0);

    // Random mix of both inputs against the model.
    for (int k = 0; k < 300; k++) begin
      drive(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      check_state("R3 R4 R5 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule